// File: doc/BRIEF.md
# Eight-Pin General-Purpose I/O Controller with Edge Interrupt

The block drives and samples eight general-purpose pins through a small register port. Five per-pin registers set each pin's direction, whether it may interrupt, its output level, whether its output driver is released, and whether its input is seen inverted. Each pin presents an input, an output value and an output-enable to an external pad.

Input pins pass through a synchronizer. After that, the inversion setting adjusts their polarity. A 0-to-1 transition of the adjusted value on an enabled input pin latches a per-pin pending flag. The flags are OR-ed into a single interrupt request. Software services the request by reading the level register, which returns the pin levels and clears every pending flag. No separate status register and no write-to-clear are involved.

Top module: `gpio_edge_irq`

## Requirements
- R1: After an asynchronous reset, every register is 0x00, `pin_o`, `pin_oe_o`, `rdata_o` and `irq_o` are all zero.
- R2: Register addresses: 0 direction (bit 1 = output), 1 interrupt enable, 2 level, 3 tri-state, 4 inversion. Bit i of each register belongs to pin i. A write stores `wdata_i` into the addressed register. Addresses 5 to 7 read as 0x00, and writes to them change nothing.
- R3: `rdata_o` updates in the cycle after `re_i` is high, with the value that the register held in the strobe cycle. A write in that same cycle is not yet visible. Without a read strobe, `rdata_o` holds its value.
- R4: `pin_o` equals the level register. Bit i of `pin_oe_o` is 1 only when pin i is an output and its tri-state bit is 0.
- R5: Reading the level register returns the stored level for output pins. For input pins it returns the synchronized pin value XOR the inversion bit.
- R6: A change on `pin_i` is seen by a level read whose strobe falls on the third rising edge after the change. Reads on the first and second edges return the old value.
- R7: An active edge is a 0-to-1 transition of the synchronized, inversion-adjusted input between consecutive cycles. With inversion 0 this is a rising pin edge, and with inversion 1 it is a falling pin edge. `irq_o` is high after the third rising clock edge following the pin change.
- R8: Only a pin configured as input with its interrupt enable at 1 can set or present a pending interrupt. With every pin set as output, `irq_o` stays low.
- R9: `irq_o` is the OR of the pending flags of enabled input pins. A pending flag stays set until a level read.
- R10: A level read clears all pending flags. An active edge latched in the same cycle as the clearing read stays pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| addr_i | input | 3 | Register address |
| wdata_i | input | 8 | Write data |
| we_i | input | 1 | Write strobe |
| re_i | input | 1 | Read strobe |
| rdata_o | output | 8 | Read data, valid the cycle after `re_i` |
| pin_i | input | 8 | Pad input levels |
| pin_o | output | 8 | Pad output levels |
| pin_oe_o | output | 8 | Pad output enables |
| irq_o | output | 1 | Interrupt request, active high |

## Verification
Latching an active edge and clearing the pending flags with a level read can fall in the same clock edge. In that case the new edge must survive the clear. A directed case times the level read onto the third edge after a pin transition, so the set and the clear hit together, and then expects `irq_o` still high, followed by low after a second read. Random traffic mixes frequent level reads with pin toggles. A cycle-level model derived from the requirements judges every cycle, so many more such collisions are compared on `irq_o` as well.

// File: rtl/gpio_edge_pkg.sv
package gpio_edge_pkg;
  localparam int ADDR_W = 3;

  typedef enum logic [ADDR_W-1:0] {
    REG_DIR = 3'd0,
    REG_IEN = 3'd1,
    REG_LVL = 3'd2,
    REG_TRI = 3'd3,
    REG_INV = 3'd4
  } reg_addr_e;
endpackage

// File: rtl/gpio_sync.sv
module gpio_sync #(
  parameter int W      = 8,
  parameter int STAGES = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [STAGES-1:0][W-1:0] chain_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      chain_q <= '0;
    end else begin
      chain_q[0] <= d_i;
      for (int s = 1; s < STAGES; s++) chain_q[s] <= chain_q[s-1];
    end
  end

  assign q_o = chain_q[STAGES-1];
endmodule

// File: rtl/gpio_edge_pend.sv
module gpio_edge_pend #(
  parameter int W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] lvl_i,   // synchronized, polarity-adjusted
  input  logic [W-1:0] arm_i,   // input pin with interrupt enabled
  input  logic         clr_i,
  output logic [W-1:0] set_o,
  output logic [W-1:0] pend_o
);
  logic [W-1:0] prev_q;
  logic [W-1:0] pend_q;
  logic [W-1:0] pend_d;

  for (genvar i = 0; i < W; i++) begin : g_pin
    assign set_o[i]  = lvl_i[i] & ~prev_q[i] & arm_i[i];
    // a set in the clearing cycle wins
    assign pend_d[i] = set_o[i] | (pend_q[i] & ~clr_i);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      prev_q <= '0;
      pend_q <= '0;
    end else begin
      prev_q <= lvl_i;
      pend_q <= pend_d;
    end
  end

  assign pend_o = pend_q;
endmodule

// File: rtl/gpio_regs.sv
module gpio_regs
  import gpio_edge_pkg::*;
#(
  parameter int W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [W-1:0]      wdata_i,
  input  logic              we_i,
  input  logic              re_i,
  input  logic [W-1:0]      in_lvl_i,
  output logic [W-1:0]      dir_o,
  output logic [W-1:0]      ien_o,
  output logic [W-1:0]      lvl_o,
  output logic [W-1:0]      tri_o,
  output logic [W-1:0]      inv_o,
  output logic [W-1:0]      rdata_o
);
  logic [W-1:0] dir_q, ien_q, lvl_q, tri_q, inv_q, rdata_q;
  logic [W-1:0] rd_mux;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      dir_q <= '0;
      ien_q <= '0;
      lvl_q <= '0;
      tri_q <= '0;
      inv_q <= '0;
    end else if (we_i) begin
      case (addr_i)
        REG_DIR: dir_q <= wdata_i;
        REG_IEN: ien_q <= wdata_i;
        REG_LVL: lvl_q <= wdata_i;
        REG_TRI: tri_q <= wdata_i;
        REG_INV: inv_q <= wdata_i;
        default: ;
      endcase
    end
  end

  always_comb begin
    case (addr_i)
      REG_DIR: rd_mux = dir_q;
      REG_IEN: rd_mux = ien_q;
      REG_LVL: rd_mux = (dir_q & lvl_q) | (~dir_q & in_lvl_i);
      REG_TRI: rd_mux = tri_q;
      REG_INV: rd_mux = inv_q;
      default: rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   rdata_q <= '0;
    else if (re_i) rdata_q <= rd_mux;
  end

  assign dir_o   = dir_q;
  assign ien_o   = ien_q;
  assign lvl_o   = lvl_q;
  assign tri_o   = tri_q;
  assign inv_o   = inv_q;
  assign rdata_o = rdata_q;
endmodule

// File: rtl/gpio_edge_irq.sv
module gpio_edge_irq
  import gpio_edge_pkg::*;
#(
  parameter int N_PINS      = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [N_PINS-1:0] wdata_i,
  input  logic              we_i,
  input  logic              re_i,
  output logic [N_PINS-1:0] rdata_o,
  input  logic [N_PINS-1:0] pin_i,
  output logic [N_PINS-1:0] pin_o,
  output logic [N_PINS-1:0] pin_oe_o,
  output logic              irq_o
);
  logic [N_PINS-1:0] sync_w, adj_w, arm_w, set_w, pend_w;
  logic [N_PINS-1:0] dir_w, ien_w, lvl_w, tri_w, inv_w;
  logic              clr_w;

  gpio_sync #(.W(N_PINS), .STAGES(SYNC_STAGES)) u_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .d_i    (pin_i),
    .q_o    (sync_w)
  );

  assign adj_w = sync_w ^ inv_w;
  assign arm_w = ien_w & ~dir_w;
  assign clr_w = re_i && (addr_i == REG_LVL);

  gpio_regs #(.W(N_PINS)) u_regs (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .addr_i   (addr_i),
    .wdata_i  (wdata_i),
    .we_i     (we_i),
    .re_i     (re_i),
    .in_lvl_i (adj_w),
    .dir_o    (dir_w),
    .ien_o    (ien_w),
    .lvl_o    (lvl_w),
    .tri_o    (tri_w),
    .inv_o    (inv_w),
    .rdata_o  (rdata_o)
  );

  gpio_edge_pend #(.W(N_PINS)) u_pend (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .lvl_i  (adj_w),
    .arm_i  (arm_w),
    .clr_i  (clr_w),
    .set_o  (set_w),
    .pend_o (pend_w)
  );

  // masking here too: a pin turned to output drops its request at once
  assign irq_o    = |(pend_w & arm_w);
  assign pin_o    = lvl_w;
  assign pin_oe_o = dir_w & ~tri_w;
endmodule

// File: rtl/gpio_edge_irq_chk.sv
module gpio_edge_irq_chk
  import gpio_edge_pkg::*;
#(
  parameter int N_PINS = 8
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic [ADDR_W-1:0] addr_i,
  input logic [N_PINS-1:0] wdata_i,
  input logic              we_i,
  input logic              re_i,
  input logic [N_PINS-1:0] rdata_o,
  input logic [N_PINS-1:0] pin_oe_o,
  input logic              irq_o,
  input logic [N_PINS-1:0] set_hit,
  input logic [N_PINS-1:0] dir_q
);
  logic lvl_rd;
  assign lvl_rd = re_i && (addr_i == REG_LVL);

  a_r3_rdata_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !re_i |=> $stable(rdata_o));

  a_r4_tri_release: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && addr_i == REG_TRI && wdata_i == '1) |=> (pin_oe_o == '0));

  a_r7_rise_cause: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(irq_o) |-> ($past(|set_hit) || $past(we_i)));

  a_r8_outputs_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dir_q == '1) |-> !irq_o);

  a_r9_irq_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (irq_o && !we_i && !lvl_rd) |=> irq_o);

  a_r10_clear: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (lvl_rd && !(|set_hit)) |=> !irq_o);
endmodule

bind gpio_edge_irq gpio_edge_irq_chk #(.N_PINS(N_PINS)) u_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .addr_i   (addr_i),
  .wdata_i  (wdata_i),
  .we_i     (we_i),
  .re_i     (re_i),
  .rdata_o  (rdata_o),
  .pin_oe_o (pin_oe_o),
  .irq_o    (irq_o),
  .set_hit  (set_w),
  .dir_q    (dir_w)
);

// File: tb/gpio_edge_irq_test.sv
`timescale 1ns/1ps
module gpio_edge_irq_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [2:0] addr = '0;
  logic [7:0] wdata = '0;
  logic       we = 1'b0;
  logic       re = 1'b0;
  logic [7:0] pin = '0;
  logic [7:0] rdata, pin_o, pin_oe;
  logic       irq;

  int checks = 0;
  int errors = 0;

  always #5 clk = ~clk;

  gpio_edge_irq uut (
    .clk_i(clk), .rst_ni(rst_n), .addr_i(addr), .wdata_i(wdata),
    .we_i(we), .re_i(re), .rdata_o(rdata), .pin_i(pin),
    .pin_o(pin_o), .pin_oe_o(pin_oe), .irq_o(irq)
  );

  // reference model built from the requirements
  logic [7:0] m_dir, m_ien, m_lvl, m_tri, m_inv, m_rdata;
  logic [7:0] m_s1, m_s2, m_prev, m_pend;

  function automatic logic [7:0] rd_val(input logic [2:0] a);
    case (a)
      3'd0: return m_dir;
      3'd1: return m_ien;
      3'd2: return (m_dir & m_lvl) | (~m_dir & (m_s2 ^ m_inv));
      3'd3: return m_tri;
      3'd4: return m_inv;
      default: return 8'h00;
    endcase
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_dir = '0; m_ien = '0; m_lvl = '0; m_tri = '0; m_inv = '0;
      m_rdata = '0; m_s1 = '0; m_s2 = '0; m_prev = '0; m_pend = '0;
    end else begin
      logic [7:0] adj, hit;
      adj = m_s2 ^ m_inv;
      hit = adj & ~m_prev & m_ien & ~m_dir;
      if (re) m_rdata = rd_val(addr);
      m_pend = (m_pend & ~{8{re && addr == 3'd2}}) | hit;
      m_prev = adj;
      m_s2 = m_s1;
      m_s1 = pin;
      if (we) begin
        case (addr)
          3'd0: m_dir = wdata;
          3'd1: m_ien = wdata;
          3'd2: m_lvl = wdata;
          3'd3: m_tri = wdata;
          3'd4: m_inv = wdata;
          default: ;
        endcase
      end
    end
  end

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic check_all();
    chk("R9 irq_o", {7'b0, irq}, {7'b0, |(m_pend & m_ien & ~m_dir)});
    chk("R4 pin_o", pin_o, m_lvl);
    chk("R4 pin_oe_o", pin_oe, m_dir & ~m_tri);
    chk("R3 rdata_o", rdata, m_rdata);
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
    check_all();
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    addr = a; wdata = d; we = 1'b1;
    step();
    we = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [7:0] v);
    addr = a; re = 1'b1;
    step();
    re = 1'b0;
    v = rdata;
  endtask

  task automatic finish_sim();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_sim();
  end

  initial begin
    logic [7:0] v;
    void'($urandom(32'd20240607));

    // R1 reset state
    repeat (3) @(negedge clk);
    chk("R1 pin_o", pin_o, 8'h00);
    chk("R1 pin_oe_o", pin_oe, 8'h00);
    chk("R1 irq_o", {7'b0, irq}, 8'h00);
    chk("R1 rdata_o", rdata, 8'h00);
    rst_n = 1'b1;
    for (int a = 0; a < 5; a++) begin
      rd(3'(a), v);
      chk("R1 register reset", v, 8'h00);
    end

    // R2 register map, R4 pad outputs
    wr(3'd0, 8'hFF);
    wr(3'd1, 8'h3C);
    wr(3'd2, 8'h96);
    wr(3'd3, 8'h0F);
    wr(3'd4, 8'h81);
    wr(3'd6, 8'h55);
    rd(3'd0, v); chk("R2 dir", v, 8'hFF);
    rd(3'd1, v); chk("R2 ien", v, 8'h3C);
    rd(3'd2, v); chk("R2 lvl", v, 8'h96);
    rd(3'd3, v); chk("R2 tri", v, 8'h0F);
    rd(3'd4, v); chk("R2 inv", v, 8'h81);
    rd(3'd6, v); chk("R2 unmapped", v, 8'h00);
    chk("R4 pin_o", pin_o, 8'h96);
    chk("R4 pin_oe_o", pin_oe, 8'hF0);

    // R3 write and read in the same cycle return the old value
    addr = 3'd1; wdata = 8'hA0; we = 1'b1; re = 1'b1;
    step();
    we = 1'b0; re = 1'b0;
    chk("R3 read beside write", rdata, 8'h3C);

    // R5/R6 input readback through synchronizer and inversion
    wr(3'd1, 8'h00);
    wr(3'd0, 8'h00);
    wr(3'd3, 8'h00);
    wr(3'd4, 8'h0F);
    pin = 8'h33;
    repeat (4) step();
    rd(3'd2, v); chk("R5 inverted readback", v, 8'h3C);
    pin = 8'hCC;
    rd(3'd2, v); chk("R6 first edge old", v, 8'h3C);
    rd(3'd2, v); chk("R6 second edge old", v, 8'h3C);
    rd(3'd2, v); chk("R6 third edge new", v, 8'hC3);

    // R7 rising edge with inversion off
    wr(3'd4, 8'h00);
    pin = 8'h00;
    repeat (4) step();
    wr(3'd1, 8'h01);
    rd(3'd2, v);
    pin = 8'h01;
    step(); chk("R7 irq after 1 edge", {7'b0, irq}, 8'h00);
    step(); chk("R7 irq after 2 edges", {7'b0, irq}, 8'h00);
    step(); chk("R7 irq after 3 edges", {7'b0, irq}, 8'h01);
    repeat (3) step();
    chk("R9 pending held", {7'b0, irq}, 8'h01);
    rd(3'd2, v); chk("R10 read clears", {7'b0, irq}, 8'h00);

    // R7 falling edge with inversion on
    wr(3'd4, 8'h02);
    repeat (3) step();
    wr(3'd1, 8'h03);
    pin = 8'h03;
    repeat (3) step();
    chk("R7 rising raw ignored when inverted", {7'b0, irq}, 8'h00);
    pin = 8'h01;
    step(); step();
    chk("R7 falling not yet", {7'b0, irq}, 8'h00);
    step();
    chk("R7 falling raised", {7'b0, irq}, 8'h01);
    rd(3'd2, v);

    // R10 edge coinciding with the clearing read
    pin = 8'h00;
    repeat (3) step();
    chk("R10 quiet before", {7'b0, irq}, 8'h00);
    pin = 8'h01;
    step(); step();
    rd(3'd2, v);
    chk("R10 edge in clear cycle kept", {7'b0, irq}, 8'h01);
    rd(3'd2, v);
    chk("R10 second read clears", {7'b0, irq}, 8'h00);

    // R8 output pin never interrupts
    wr(3'd0, 8'h01);
    pin = 8'h00;
    repeat (3) step();
    pin = 8'h01;
    repeat (4) step();
    chk("R8 output pin edge", {7'b0, irq}, 8'h00);
    rd(3'd2, v); chk("R5 mixed readback", v, 8'h02);

    // random traffic judged every cycle by the model
    for (int i = 0; i < 4000; i++) begin
      pin   = pin ^ 8'($urandom & $urandom & $urandom);
      we    = ($urandom % 4) == 0;
      re    = ($urandom % 3) == 0;
      addr  = ($urandom % 2) ? 3'd2 : 3'($urandom % 8);
      wdata = 8'($urandom);
      step();
    end
    we = 1'b0;
    re = 1'b0;
    step();
    finish_sim();
  end
endmodule